// File: doc/BRIEF.md
# Fixed-Latency Handshake Multiplier

This block multiplies two unsigned operands and hands the result back to a parent controller after a fixed number of cycles set by a parameter. The parent starts a job by raising `go` from idle. Both operands are sampled in that first cycle only. The parent then keeps `go` high until it sees `done`, and lowers it after that cycle.

`done` marks the single cycle in which the result first appears. The product then stays unchanged for that cycle and the following one. Because of this, a caller can feed the result straight back as an operand of the next job on the same instance, and that next job may start in the cycle right after `done`. If `go` drops early, the job is abandoned and no `done` is raised.

Top module: `seq_multiplier`

## Requirements
- R1: If `go` is first seen high while idle in cycle G, `done` is high in cycle G+LATENCY, and not before that cycle within this job.
- R2: Operands are sampled only in cycle G. Changing `leftOp` or `rightOp` in later cycles of the job does not change the result.
- R3: `done` stays high for exactly one cycle per completed job.
- R4: In cycle G+LATENCY, `product` equals the unsigned product `leftOp*rightOp` (2*WIDTH bits) of the sampled operands. It stays at that value in cycle G+LATENCY+1.
- R5: `product` keeps its value until a later completed job writes a new result.
- R6: If `go` is high in cycle G+LATENCY+1, a new job starts in that cycle. A product fed back as an operand in that cycle is used correctly.
- R7: If `go` is low in any cycle from G+1 to G+LATENCY-1, the job is abandoned. `done` stays low, and `product` keeps its previous value.
- R8: After reset, `done` is low and `product` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start, then held high through the done cycle |
| leftOp | input | WIDTH | First operand, sampled in the start cycle |
| rightOp | input | WIDTH | Second operand, sampled in the start cycle |
| done | output | 1 | One-cycle completion pulse |
| product | output | 2*WIDTH | Result, valid from the done cycle for two cycles |

## Verification
The hardest case to reach from the ports is a job that starts in the very cycle after `done`, with the previous result fed back as an operand. At that moment the controller leaves its done state, the old product must still be visible, and a new capture happens on the same edge. The bench's random sequence often continues straight into the next job, sometimes feeding back the expected product. It also drops `go` early at random points and scrambles the operands after the start cycle. In each case the bench confirms that only the start-cycle values determine the result.

// File: rtl/mul_pkg.sv
package mul_pkg;
  typedef struct packed {
    logic capture;
    logic finish;
  } mulStrobe_t;

  typedef enum logic {ST_IDLE, ST_RUN} mulState_t;
endpackage

// File: rtl/mul_ctrl.sv
module mul_ctrl
  import mul_pkg::*;
#(
  parameter int LATENCY = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       go,
  output mulStrobe_t strobe,
  output logic       done
);
  localparam int CW = $clog2(LATENCY + 1);
  localparam logic [CW-1:0] LAST = CW'(LATENCY);
  localparam logic [CW-1:0] PRE  = CW'(LATENCY - 1);

  mulState_t state;
  logic [CW-1:0] count;

  always_comb begin
    strobe.capture = (state == ST_IDLE) && go;
    if (LATENCY == 1) strobe.finish = strobe.capture;
    else              strobe.finish = (state == ST_RUN) && (count == PRE) && go;
    done = (state == ST_RUN) && (count == LAST);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      count <= '0;
    end else if (state == ST_IDLE) begin
      if (go) begin
        state <= ST_RUN;
        count <= CW'(1);
      end
    end else if (count == LAST || !go) begin
      state <= ST_IDLE;
      count <= '0;
    end else begin
      count <= count + CW'(1);
    end
  end

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_needs_go_r1: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(go));

  p_abort_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && count != LAST && !go) |=> (!done && state == ST_IDLE));
endmodule

// File: rtl/mul_dp.sv
module mul_dp
  import mul_pkg::*;
#(
  parameter int WIDTH   = 8,
  parameter int LATENCY = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  mulStrobe_t       strobe,
  input  logic [WIDTH-1:0] leftOp,
  input  logic [WIDTH-1:0] rightOp,
  output logic [2*WIDTH-1:0] product
);
  localparam int PW = 2 * WIDTH;

  generate
    if (LATENCY == 1) begin : g_direct
      always_ff @(posedge clk) begin
        if (!rstN) product <= '0;
        else if (strobe.finish) product <= PW'(leftOp) * PW'(rightOp);
      end
    end else begin : g_staged
      logic [WIDTH-1:0] opA, opB;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          opA <= '0;
          opB <= '0;
        end else if (strobe.capture) begin
          opA <= leftOp;
          opB <= rightOp;
        end
      end
      always_ff @(posedge clk) begin
        if (!rstN) product <= '0;
        else if (strobe.finish) product <= PW'(opA) * PW'(opB);
      end
    end
  endgenerate

  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.finish |=> $stable(product));
endmodule

// File: rtl/seq_multiplier.sv
module seq_multiplier
  import mul_pkg::*;
#(
  parameter int WIDTH   = 8,
  parameter int LATENCY = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               go,
  input  logic [WIDTH-1:0]   leftOp,
  input  logic [WIDTH-1:0]   rightOp,
  output logic               done,
  output logic [2*WIDTH-1:0] product
);
  mulStrobe_t strobe;

  mul_ctrl #(.LATENCY(LATENCY)) u_ctrl (
    .clk(clk), .rstN(rstN), .go(go), .strobe(strobe), .done(done)
  );

  mul_dp #(.WIDTH(WIDTH), .LATENCY(LATENCY)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .leftOp(leftOp), .rightOp(rightOp), .product(product)
  );

  p_product_stable_r4: assert property (@(posedge clk) disable iff (!rstN)
    done |=> $stable(product));
endmodule

// File: tb/seq_multiplier_tb.sv
module seq_multiplier_tb;
  localparam int W = 8;
  localparam int L = 3;

  logic clk = 0;
  logic rstN = 0;
  logic go = 0;
  logic [W-1:0] leftOp = '0, rightOp = '0;
  logic done;
  logic [2*W-1:0] product;
  int checks = 0;
  int errors = 0;
  logic [2*W-1:0] expProd = '0;

  always #5 clk = ~clk;

  seq_multiplier #(.WIDTH(W), .LATENCY(L)) u_dut (
    .clk(clk), .rstN(rstN), .go(go), .leftOp(leftOp), .rightOp(rightOp),
    .done(done), .product(product)
  );

  function automatic logic [2*W-1:0] mulRef(logic [W-1:0] a, logic [W-1:0] b);
    return {{W{1'b0}}, a} * {{W{1'b0}}, b};
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // Called at a negedge; starts a job whose start cycle follows this negedge.
  task automatic runJob(logic [W-1:0] a, logic [W-1:0] b);
    logic [2*W-1:0] oldProd = expProd;
    go = 1; leftOp = a; rightOp = b;
    for (int k = 1; k <= L; k++) begin
      @(negedge clk);
      if (k == 1) begin
        leftOp = W'($urandom); rightOp = W'($urandom); // R2 scramble
      end
      if (k < L) begin
        check(done == 0, "R1 early done", done, 0);
        check(product == oldProd, "R5 product held while busy", product, oldProd);
      end else begin
        check(done == 1, "R1 done at G+L", done, 1);
        check(product == mulRef(a, b), "R4 R2 product at done", product, mulRef(a, b));
      end
    end
    expProd = mulRef(a, b);
    @(negedge clk);
    check(done == 0, "R3 done one cycle", done, 0);
    check(product == expProd, "R4 product second cycle", product, expProd);
  endtask

  task automatic abortJob(logic [W-1:0] a, logic [W-1:0] b, int keep);
    go = 1; leftOp = a; rightOp = b;
    for (int k = 0; k < keep; k++) @(negedge clk);
    go = 0;
    for (int k = 0; k < L + 2; k++) begin
      @(negedge clk);
      check(done == 0, "R7 no done after abort", done, 0);
      check(product == expProd, "R7 product kept after abort", product, expProd);
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(done == 0, "R8 reset done", done, 0);
    check(product == 0, "R8 reset product", product, 0);
    rstN = 1;
    @(negedge clk);
    check(done == 0, "R8 idle after reset", done, 0);

    runJob(8'd255, 8'd255);
    go = 0; @(negedge clk);
    runJob(8'd0, 8'd77);
    runJob(8'd12, 8'd13);              // R6 back-to-back
    runJob(expProd[W-1:0], 8'd3);      // R6 chained feedback
    go = 0; @(negedge clk);
    abortJob(8'd9, 8'd9, 1);           // R7 drop in G+1
    abortJob(8'd5, 8'd6, L - 1);       // R7 drop in G+L-1
    runJob(8'd200, 8'd2);

    for (int i = 0; i < 60; i++) begin
      int sel = int'($urandom_range(0, 9));
      if (sel < 2) begin
        abortJob(W'($urandom), W'($urandom), int'($urandom_range(1, L - 1)));
      end else if (sel < 4) begin
        runJob(expProd[W-1:0], W'($urandom)); // R6 chained
      end else begin
        runJob(W'($urandom), W'($urandom));
      end
      if ($urandom_range(0, 2) == 0) begin
        go = 0;
        repeat (int'($urandom_range(1, 3))) begin
          @(negedge clk);
          check(done == 0, "R5 idle no done", done, 0);
          check(product == expProd, "R5 idle product held", product, expProd);
        end
      end
    end
    go = 0;
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule